// File: doc/BRIEF.md
# Serial Control-Register Write Slave

This block is a write-only slave on a two-wire serial bus (I2C-style signalling) that loads a small bank of 8-bit control registers. SCL and SDA are brought into the system clock domain and watched for start and stop conditions. After a start, the block compares the first byte with its fixed device address and a write direction bit. The second byte selects a register and the addressing mode. Each later byte is written into the register bank, and the block acknowledges every byte it accepts by pulling SDA low.

The subaddress byte chooses the mode for the whole transaction. With the mode flag clear, every data byte lands in the same register. With the flag set, the register index steps up by one after each byte. The index is four bits wide, but only the lower eight indices hold storage. Bytes aimed at indices 8 to 15 are still acknowledged and then dropped. The register contents appear on a flat parallel output bus, and the surrounding logic uses that bus directly.

Top module: `ctrl_reg_serial_slave`

## Requirements
- R1: Reset clears every register to 0x00 and releases SDA (sda_pull_o = 0).
- R2: Only the address byte 0x88 (device address 1000100 then write bit 0) is acknowledged. A byte with another address, or with the direction bit set, gets no acknowledge, and every later byte is ignored and not acknowledged until the next start.
- R3: The subaddress byte is acknowledged. In that byte, bit 4 is the increment flag, bits 3..0 are the register index, and bits 7..5 have no effect.
- R4: With the increment flag at 0, every data byte of the transaction is written to the one indexed register, so the last byte wins.
- R5: With the increment flag at 1, the first data byte goes to the indexed register and each later byte goes to the previous index plus one.
- R6: Data bytes addressed to indices 8..15 are acknowledged but change no register.
- R7: In increment mode the index wraps from 15 back to 0.
- R8: A repeated start at any point abandons the byte in progress and restarts address matching. Bytes already acknowledged keep their writes.
- R9: The acknowledge pull starts after the falling SCL that ends the 8th bit and is held through the high phase of the 9th clock. It is released after the 9th falling SCL.
- R10: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. After a stop, bytes clocked without a new start are not acknowledged.

Register n is carried on regs_o[8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_o | output | 1 | 1 pulls SDA low (acknowledge) |
| regs_o | output | NREGS*8 | Register bank contents, register n at bits 8n+7..8n |

## Verification
The write path is tried with subaddress patterns from a table. The patterns cover the flag clear and set, an index that starts inside the bank and runs past index 7, an index that starts at 14 and wraps to 0, and an index in the discarded range. Some patterns also set the don't-care bits. Comparing the bank after each pattern against a model of the rules separates the same-register mode from the stepping mode, and stored indices from discarded ones. Acknowledge counts separate accepted addresses from a foreign address, a read direction bit and bytes sent after a stop. A repeated start in the middle of a byte shows whether earlier writes are kept and a partial byte is dropped.

// File: rtl/crs_pkg.sv
package crs_pkg;

    localparam int CRS_BYTE_W  = 8;
    localparam int CRS_IDX_W   = 4;
    localparam int CRS_INC_BIT = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA,
        ST_SKIP
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic                  en;
        logic [CRS_IDX_W-1:0]  idx;
        logic [CRS_BYTE_W-1:0] data;
    } wr_req_t;

    // Address byte = 7-bit device address followed by a 0 (write) bit.
    function automatic logic addr_hit(input logic [CRS_BYTE_W-1:0] b,
                                      input logic [6:0] dev);
        return b == {dev, 1'b0};
    endfunction

endpackage

// File: rtl/crs_bus_sampler.sv
module crs_bus_sampler
    import crs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int CHAIN = SYNC_STAGES + 1;
    localparam int L_SDA = 0;
    localparam int L_SCL = 1;

    logic [1:0] raw;
    logic [1:0] cur;
    logic [1:0] prev;

    assign raw = {scl_i, sda_i};

    for (genvar l = 0; l < 2; l++) begin : g_line
        logic [CHAIN-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[CHAIN-2:0], raw[l]};
        end
        assign cur[l]  = chain[CHAIN-2];
        assign prev[l] = chain[CHAIN-1];
    end

    always_comb begin
        ev.scl_rise = cur[L_SCL] & ~prev[L_SCL];
        ev.scl_fall = ~cur[L_SCL] & prev[L_SCL];
        ev.start    = cur[L_SCL] & prev[L_SCL] & prev[L_SDA] & ~cur[L_SDA];
        ev.stop     = cur[L_SCL] & prev[L_SCL] & ~prev[L_SDA] & cur[L_SDA];
        ev.sda      = cur[L_SDA];
    end

endmodule

// File: rtl/crs_byte_engine.sv
module crs_byte_engine
    import crs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h44
) (
    input  logic    clk,
    input  logic    rst,
    input  bus_ev_t ev,
    output logic    sda_pull,
    output wr_req_t wr,
    output phase_e  phase
);
    localparam int CNT_W    = $clog2(CRS_BYTE_W + 2);
    localparam int LAST_BIT = CRS_BYTE_W;
    localparam int ACK_SLOT = CRS_BYTE_W + 1;

    logic [CNT_W-1:0]      bit_cnt;
    logic [CRS_BYTE_W-1:0] shreg;
    logic [CRS_IDX_W-1:0]  idx;
    logic                  inc;
    logic                  active;

    assign active = (phase == ST_ADDR) || (phase == ST_SUB) || (phase == ST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            sda_pull <= 1'b0;
            idx      <= '0;
            inc      <= 1'b0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                phase    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (ev.stop) begin
                phase    <= ST_IDLE;
                bit_cnt  <= '0;
                sda_pull <= 1'b0;
            end else if (active) begin
                if (ev.scl_rise && bit_cnt < CNT_W'(LAST_BIT)) begin
                    shreg   <= {shreg[CRS_BYTE_W-2:0], ev.sda};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (ev.scl_fall && bit_cnt == CNT_W'(LAST_BIT)) begin
                    bit_cnt <= CNT_W'(ACK_SLOT);
                    unique case (phase)
                        ST_ADDR: begin
                            if (addr_hit(shreg, DEV_ADDR)) begin
                                sda_pull <= 1'b1;
                                phase    <= ST_SUB;
                            end else begin
                                phase    <= ST_SKIP;
                            end
                        end
                        ST_SUB: begin
                            sda_pull <= 1'b1;
                            idx      <= shreg[CRS_IDX_W-1:0];
                            inc      <= shreg[CRS_INC_BIT];
                            phase    <= ST_DATA;
                        end
                        default: begin
                            sda_pull <= 1'b1;
                            wr.en    <= 1'b1;
                            wr.idx   <= idx;
                            wr.data  <= shreg;
                            if (inc) idx <= idx + 1'b1;
                        end
                    endcase
                end else if (ev.scl_fall && bit_cnt == CNT_W'(ACK_SLOT)) begin
                    bit_cnt  <= '0;
                    sda_pull <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/crs_reg_bank.sv
module crs_reg_bank
    import crs_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  wr_req_t                     wr,
    output logic [NREGS*CRS_BYTE_W-1:0] regs
);
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [CRS_BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (wr.en && wr.idx == CRS_IDX_W'(g))
                q <= wr.data;
        end
        assign regs[g*CRS_BYTE_W +: CRS_BYTE_W] = q;
    end

endmodule

// File: rtl/ctrl_reg_serial_slave.sv
module ctrl_reg_serial_slave
    import crs_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h44,
    parameter int         NREGS       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        scl_i,
    input  logic                        sda_i,
    output logic                        sda_pull_o,
    output logic [NREGS*CRS_BYTE_W-1:0] regs_o
);
    bus_ev_t ev;
    wr_req_t wr;
    phase_e  phase;

    crs_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    crs_byte_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .sda_pull (sda_pull_o),
        .wr       (wr),
        .phase    (phase)
    );

    crs_reg_bank #(.NREGS(NREGS)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .regs (regs_o)
    );

endmodule

// File: rtl/crs_checker.sv
module crs_checker
    import crs_pkg::*;
#(
    parameter int NREGS = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        scl_fall,
    input logic                        start,
    input logic                        stop,
    input phase_e                      phase,
    input logic                        sda_pull,
    input logic                        wr_en,
    input logic [CRS_IDX_W-1:0]        wr_idx,
    input logic [NREGS*CRS_BYTE_W-1:0] regs
);
    // R1
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (regs == '0 && !sda_pull));

    // R2
    a_r2_quiet_when_not_selected: assert property (@(posedge clk) disable iff (rst)
        (phase == ST_IDLE || phase == ST_SKIP) |-> !sda_pull);

    // R4
    a_r4_bank_holds_without_write: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs));

    // R6
    a_r6_high_index_discarded: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx >= CRS_IDX_W'(NREGS)) |=> $stable(regs));

    // R8
    a_r8_start_rearms: assert property (@(posedge clk) disable iff (rst)
        start |=> (phase == ST_ADDR && !sda_pull));

    // R9
    a_r9_pull_moves_on_scl_fall: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull) |-> ($past(scl_fall) || $past(start) || $past(stop)));

endmodule

bind ctrl_reg_serial_slave crs_checker #(.NREGS(NREGS)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_fall (ev.scl_fall),
    .start    (ev.start),
    .stop     (ev.stop),
    .phase    (phase),
    .sda_pull (sda_pull_o),
    .wr_en    (wr.en),
    .wr_idx   (wr.idx),
    .regs     (regs_o)
);

// File: tb/ctrl_reg_serial_slave_bench.sv
module ctrl_reg_serial_slave_bench;

    localparam int Q     = 10;
    localparam int NREGS = 8;
    localparam int NVEC  = 8;

    // {subaddress, byte count, data0..data3}
    localparam logic [47:0] VEC [NVEC] = '{
        {8'h10, 8'd4, 32'h01020304},   // R5 step from 0
        {8'h05, 8'd3, 32'hAABBCC00},   // R4 same register, last wins
        {8'h16, 8'd4, 32'h61626364},   // R5/R6 run past index 7
        {8'hE3, 8'd1, 32'h5A000000},   // R3 bits 7..5 ignored
        {8'h0C, 8'd2, 32'h77880000},   // R6 fixed high index
        {8'hFE, 8'd4, 32'h91929394},   // R7 wrap 15 -> 0
        {8'h34, 8'd2, 32'h0FF00000},   // R3/R5 flag with don't-care bit
        {8'h07, 8'd1, 32'h00000000}    // R4 write zero
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic pull;
    logic [NREGS*8-1:0] regs;
    logic [7:0] model [NREGS];
    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~pull;

    ctrl_reg_serial_slave u_ctrl_reg_serial_slave (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (pull),
        .regs_o     (regs)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clks(Q);
        scl_m = 1'b1; wait_clks(Q);
        sda_m = 1'b0; wait_clks(Q);
        scl_m = 1'b0; wait_clks(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clks(Q);
        scl_m = 1'b1; wait_clks(Q);
        sda_m = 1'b1; wait_clks(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wait_clks(Q);
            scl_m = 1'b1; wait_clks(Q);
            scl_m = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; wait_clks(Q);
        scl_m = 1'b1; wait_clks(Q / 2);
        acked = pull;
        wait_clks(Q / 2);
        scl_m = 1'b0; wait_clks(Q);
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int i = 0; i < NREGS; i++) f[i*8 +: 8] = model[i];
        return f;
    endfunction

    initial begin
        logic a;
        int acks;
        for (int i = 0; i < NREGS; i++) model[i] = 8'h00;
        wait_clks(5);
        rst = 1'b0;
        wait_clks(5);
        // R1 reset state
        check("R1 regs after reset", regs, 64'h0);
        check("R1 sda released", {63'h0, pull}, 64'h0);

        // table walk: R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] sub;
            int n;
            logic [3:0] idx;
            sub = VEC[v][47:40];
            n = int'(VEC[v][39:32]);
            idx = sub[3:0];
            acks = 0;
            bus_start();
            send_byte(8'h88, a); acks += int'(a);
            send_byte(sub, a); acks += int'(a);
            for (int k = 0; k < n; k++) begin
                logic [7:0] d;
                d = VEC[v][31 - 8*k -: 8];
                send_byte(d, a); acks += int'(a);
                if (idx < 4'd8) model[idx[2:0]] = d;
                if (sub[4]) idx = idx + 4'd1;
            end
            bus_stop();
            wait_clks(Q);
            check("R3/R4/R5/R6/R7 bank after vector", regs, model_flat());
            check("R3/R6/R9 ack count", 64'(acks), 64'(n + 2));
        end

        // R2 foreign address: no ack and nothing written
        acks = 0;
        bus_start();
        send_byte(8'h8A, a); acks += int'(a);
        send_byte(8'h10, a); acks += int'(a);
        send_byte(8'h55, a); acks += int'(a);
        bus_stop();
        wait_clks(Q);
        check("R2 foreign address acks", 64'(acks), 64'h0);
        check("R2 foreign address bank", regs, model_flat());

        // R2 read direction bit
        bus_start();
        send_byte(8'h89, a);
        check("R2 read bit not acked", {63'h0, a}, 64'h0);
        send_byte(8'h00, a);
        send_byte(8'hEE, a);
        bus_stop();
        wait_clks(Q);
        check("R2 read bit bank", regs, model_flat());

        // R9 release after ninth clock
        bus_start();
        send_byte(8'h88, a);
        check("R9 ack on address", {63'h0, a}, 64'h1);
        check("R9 released after ninth fall", {63'h0, pull}, 64'h0);
        bus_stop();
        wait_clks(Q);

        // R10 bytes after a stop without a new start
        send_byte(8'h88, a);
        check("R10 no ack without start", {63'h0, a}, 64'h0);
        wait_clks(Q);

        // R8 repeated start mid-byte
        bus_start();
        send_byte(8'h88, a);
        send_byte(8'h02, a);
        send_byte(8'h11, a);
        model[2] = 8'h11;
        send_bits(8'h99, 4);
        bus_start();
        send_byte(8'h88, a);
        check("R8 address matched after repeated start", {63'h0, a}, 64'h1);
        send_byte(8'h03, a);
        send_byte(8'h22, a);
        model[3] = 8'h22;
        bus_stop();
        wait_clks(Q);
        check("R8 kept and new writes", regs, model_flat());

        // R1 reset after writes
        rst = 1'b1;
        wait_clks(3);
        rst = 1'b0;
        wait_clks(2);
        check("R1 bank cleared by reset", regs, 64'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule